// File: doc/BRIEF.md
# Serial Receiver with Slave-Address Filtering

This block receives asynchronous serial frames of eight or nine data bits and passes a frame on only when it concerns this node. The receive line is oversampled by a baud tick that pulses sixteen times per bit period. Each bit is decided by a two-of-three vote around the middle of the bit. Data bits arrive least significant first. In nine-bit frames the extra bit marks a frame as an address frame in a shared multi-drop bus.

When address filtering is enabled, a frame raises the ready flag only if its byte equals the node's own address or the broadcast address. The node address is the slave address with the bits that are not compared left as don't-care. The broadcast address is the OR of slave address and compare mask, with its zero bits left as don't-care. A missing stop bit sets a sticky framing-error flag, which only its clear strobe removes. While the ready flag is still set, any newly completed frame is dropped.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset the ready flag, the framing-error flag, the data byte and the ninth-bit output are all 0.
- R2: With filtering off and eight-bit frames (frameNine=0), a frame of start bit, eight data bits sent least significant bit first and a high stop bit sets the ready flag. The received byte appears on rxData, and rxBit9 shows the stop-bit value (1). This holds for any baud-tick rate.
- R3: With frameNine=1, the bit that follows the eighth data bit is delivered on rxBit9, and the stop bit comes after it.
- R4: A low pulse on the idle line that has ended before the middle of the start bit is rejected: no flag is set and the outputs are unchanged.
- R5: A stop bit sampled low sets frameErr. The flag stays set through later frames that have valid stop bits.
- R6: While rxReady is set, a newly completed frame is discarded, and rxData and rxBit9 keep their values.
- R7: With filtering on and nine-bit frames, a frame raises rxReady only if its ninth bit is 1 and its byte matches the node address. A byte matches when it equals slaveAddr in every bit position where addrMask holds 1. Frames whose ninth bit is 0 are ignored.
- R8: With filtering on, a byte also matches when it has a 1 in every position where (slaveAddr | addrMask) has a 1.
- R9: With filtering on and eight-bit frames, a matching byte raises rxReady only if its stop bit is high. A low stop bit still sets frameErr.
- R10: A one-cycle pulse on clrReady clears rxReady, and a one-cycle pulse on clrFrameErr clears frameErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial receive line, idle high |
| baudTick | input | 1 | Oversampling strobe, 16 per bit |
| frameNine | input | 1 | 1 selects nine-bit frames |
| addrFilterEn | input | 1 | Enables address filtering |
| slaveAddr | input | 8 | Node address |
| addrMask | input | 8 | 1 marks a compared address bit |
| clrReady | input | 1 | Clears rxReady |
| clrFrameErr | input | 1 | Clears frameErr |
| rxData | output | 8 | Last accepted byte |
| rxBit9 | output | 1 | Ninth bit, or stop bit in eight-bit frames |
| rxReady | output | 1 | Frame-ready flag |
| frameErr | output | 1 | Sticky framing-error flag |

## Verification
The flags and the data byte are updated at the baud tick that votes on the stop bit. That is about ten ticks into the stop bit, plus the two-flop synchronizer delay. The bench therefore holds the stop level for a full bit period and samples four cycles later on a falling clock edge, when every result has settled. A clear strobe acts at the next rising edge, so its effect is checked on the following falling edge. A rejected start glitch is checked about three bit periods after it, and a rejected or discarded frame is checked one full frame time after it, so that any erroneous update would already be visible.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_NINTH, ST_STOP
  } rxState_t;

  typedef struct packed {
    logic takeA;      // first mid-bit sample
    logic takeB;      // second mid-bit sample
    logic shiftIn;    // vote lands in the data shifter
    logic loadNinth;  // vote lands in the ninth-bit register
    logic finish;     // vote is the stop bit, frame complete
    logic is9;        // frame carries a ninth bit
  } rxStrobe_t;
endpackage

// File: rtl/uartrx_ctrl.sv
module uartrx_ctrl
  import uartrx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      frameNine,
  input  logic      rxSync,
  input  logic      voteBit,
  output rxStrobe_t stb
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_A    = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] CNT_B    = CNT_W'(OVERSAMPLE/2);
  localparam logic [CNT_W-1:0] CNT_EVAL = CNT_W'(OVERSAMPLE/2 + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

  rxState_t state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic is9Lat;
  logic busy, evalNow, wrapNow;

  assign busy    = (state != ST_IDLE);
  assign evalNow = busy && baudTick && (tickCnt == CNT_EVAL);
  assign wrapNow = busy && baudTick && (tickCnt == CNT_LAST);

  always_comb begin
    stb           = '0;
    stb.is9       = is9Lat;
    stb.takeA     = busy && baudTick && (tickCnt == CNT_A);
    stb.takeB     = busy && baudTick && (tickCnt == CNT_B);
    stb.shiftIn   = evalNow && (state == ST_DATA);
    stb.loadNinth = evalNow && (state == ST_NINTH);
    stb.finish    = evalNow && (state == ST_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      is9Lat  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (baudTick && !rxSync) begin
            state   <= ST_START;
            tickCnt <= '0;
            bitIdx  <= '0;
            is9Lat  <= frameNine;
          end
        end
        default: begin
          if (baudTick) tickCnt <= tickCnt + 1'b1;
          if (evalNow && state == ST_START && voteBit) begin
            state <= ST_IDLE;        // false start
          end else if (evalNow && state == ST_STOP) begin
            state <= ST_IDLE;        // frame done at mid stop bit
          end else if (wrapNow) begin
            tickCnt <= '0;
            case (state)
              ST_START: state <= ST_DATA;
              ST_DATA: begin
                bitIdx <= bitIdx + 1'b1;
                if (bitIdx == IDX_LAST) state <= is9Lat ? ST_NINTH : ST_STOP;
              end
              ST_NINTH: state <= ST_STOP;
              default:  state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R2: strobes toward the datapath never overlap
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.takeA, stb.takeB, stb.shiftIn, stb.loadNinth, stb.finish}));

  // R4: a start bit voted high sends the receiver back to idle
  p_false_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && evalNow && voteBit) |=> state == ST_IDLE);

  // R3: a ninth-bit slot is only entered for nine-bit frames
  p_ninth_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NINTH) |-> is9Lat);
endmodule

// File: rtl/uartrx_dp.sv
module uartrx_dp
  import uartrx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            stb,
  input  logic                 addrFilterEn,
  input  logic [DATA_BITS-1:0] slaveAddr,
  input  logic [DATA_BITS-1:0] addrMask,
  input  logic                 clrReady,
  input  logic                 clrFrameErr,
  output logic                 rxSync,
  output logic                 voteBit,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxReady,
  output logic                 frameErr
);
  logic [1:0] syncReg;
  logic sampA, sampB;
  logic [DATA_BITS-1:0] shiftReg;
  logic ninthReg;
  logic [DATA_BITS-1:0] bcastAddr;
  logic hitOwn, hitBcast, addrHit, passFilter, acceptNow;

  assign rxSync  = syncReg[1];
  assign voteBit = (sampA & sampB) | (sampA & rxSync) | (sampB & rxSync);

  assign bcastAddr  = slaveAddr | addrMask;
  assign hitOwn     = ((shiftReg ^ slaveAddr) & addrMask) == '0;
  assign hitBcast   = (shiftReg & bcastAddr) == bcastAddr;
  assign addrHit    = hitOwn | hitBcast;

  always_comb begin
    if (!addrFilterEn)  passFilter = 1'b1;
    else if (stb.is9)   passFilter = ninthReg & addrHit;
    else                passFilter = voteBit & addrHit;
  end

  assign acceptNow = stb.finish && passFilter && !rxReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg  <= 2'b11;
      sampA    <= 1'b1;
      sampB    <= 1'b1;
      shiftReg <= '0;
      ninthReg <= 1'b0;
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxReady  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      syncReg <= {syncReg[0], rxLine};
      if (stb.takeA)     sampA    <= rxSync;
      if (stb.takeB)     sampB    <= rxSync;
      if (stb.shiftIn)   shiftReg <= {voteBit, shiftReg[DATA_BITS-1:1]};
      if (stb.loadNinth) ninthReg <= voteBit;

      if (acceptNow) begin
        rxData  <= shiftReg;
        rxBit9  <= stb.is9 ? ninthReg : voteBit;
        rxReady <= 1'b1;
      end else if (clrReady) begin
        rxReady <= 1'b0;
      end

      if (stb.finish && !voteBit) frameErr <= 1'b1;
      else if (clrFrameErr)       frameErr <= 1'b0;
    end
  end

  // R6: a pending frame is held, unchanged, until cleared
  p_hold_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !clrReady) |=> rxReady && $stable(rxData) && $stable(rxBit9));

  // R5: framing error is sticky
  p_fe_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clrFrameErr) |=> frameErr);

  // R5: framing error only rises from a low stop-bit vote
  p_fe_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(stb.finish && !voteBit));

  // R2: ready only rises at frame completion
  p_ready_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(stb.finish));
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uartrx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 baudTick,
  input  logic                 frameNine,
  input  logic                 addrFilterEn,
  input  logic [DATA_BITS-1:0] slaveAddr,
  input  logic [DATA_BITS-1:0] addrMask,
  input  logic                 clrReady,
  input  logic                 clrFrameErr,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxReady,
  output logic                 frameErr
);
  rxStrobe_t stb;
  logic rxSync, voteBit;

  uartrx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .frameNine(frameNine),
    .rxSync(rxSync), .voteBit(voteBit), .stb(stb)
  );

  uartrx_dp #(.DATA_BITS(DATA_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .stb(stb),
    .addrFilterEn(addrFilterEn), .slaveAddr(slaveAddr), .addrMask(addrMask),
    .clrReady(clrReady), .clrFrameErr(clrFrameErr),
    .rxSync(rxSync), .voteBit(voteBit),
    .rxData(rxData), .rxBit9(rxBit9), .rxReady(rxReady), .frameErr(frameErr)
  );
endmodule

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;
  localparam int CLK_PERIOD = 10;
  localparam int OS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic baudTick;
  logic frameNine = 1'b0;
  logic addrFilterEn = 1'b0;
  logic [7:0] slaveAddr = 8'h00;
  logic [7:0] addrMask = 8'h00;
  logic clrReady = 1'b0;
  logic clrFrameErr = 1'b0;
  logic [7:0] rxData;
  logic rxBit9, rxReady, frameErr;

  int tickDiv = 1;
  int tickCnt = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tickCnt <= (tickCnt + 1 >= tickDiv) ? 0 : tickCnt + 1;
  assign baudTick = (tickCnt == 0);

  uart_addr_rx i_uart_addr_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(baudTick),
    .frameNine(frameNine), .addrFilterEn(addrFilterEn),
    .slaveAddr(slaveAddr), .addrMask(addrMask),
    .clrReady(clrReady), .clrFrameErr(clrFrameErr),
    .rxData(rxData), .rxBit9(rxBit9), .rxReady(rxReady), .frameErr(frameErr)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (OS * tickDiv) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic nine, input logic b9,
                           input logic stopV);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    if (nine) holdBit(b9);
    holdBit(stopV);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseClrReady();
    clrReady = 1'b1; @(negedge clk); clrReady = 1'b0;
  endtask

  task automatic pulseClrFe();
    clrFrameErr = 1'b1; @(negedge clk); clrFrameErr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] bc;
    logic expHit;
    repeat (3) @(negedge clk);
    check("R1 ready", {15'd0, rxReady}, 16'd0);
    check("R1 frameErr", {15'd0, frameErr}, 16'd0);
    check("R1 data", {8'd0, rxData}, 16'd0);
    check("R1 bit9", {15'd0, rxBit9}, 16'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 sweep of every byte, eight-bit frames, no filtering
    for (int v = 0; v < 256; v++) begin
      sendFrame(8'(v), 1'b0, 1'b0, 1'b1);
      check("R2 ready", {15'd0, rxReady}, 16'd1);
      check("R2 data", {8'd0, rxData}, 16'(v));
      check("R2 bit9 stop", {15'd0, rxBit9}, 16'd1);
      pulseClrReady();
      check("R10 ready cleared", {15'd0, rxReady}, 16'd0);
    end

    // R3 nine-bit frames
    frameNine = 1'b1;
    sendFrame(8'h3C, 1'b1, 1'b1, 1'b1);
    check("R3 data", {8'd0, rxData}, 16'h3C);
    check("R3 bit9 one", {15'd0, rxBit9}, 16'd1);
    pulseClrReady();
    sendFrame(8'hC3, 1'b1, 1'b0, 1'b1);
    check("R3 data", {8'd0, rxData}, 16'hC3);
    check("R3 bit9 zero", {15'd0, rxBit9}, 16'd0);
    pulseClrReady();
    frameNine = 1'b0;

    // R2 slower tick rate
    tickDiv = 3;
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R2 slow tick data", {8'd0, rxData}, 16'hA5);
    check("R2 slow tick ready", {15'd0, rxReady}, 16'd1);
    pulseClrReady();
    tickDiv = 1;
    repeat (4) @(negedge clk);

    // R4 start glitch
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * OS) @(negedge clk);
    check("R4 glitch ready", {15'd0, rxReady}, 16'd0);
    check("R4 glitch data", {8'd0, rxData}, 16'hA5);
    check("R4 glitch fe", {15'd0, frameErr}, 16'd0);

    // R5 framing error, sticky
    sendFrame(8'h11, 1'b0, 1'b0, 1'b0);
    check("R5 fe set", {15'd0, frameErr}, 16'd1);
    check("R5 data with bad stop", {8'd0, rxData}, 16'h11);
    pulseClrReady();
    sendFrame(8'h22, 1'b0, 1'b0, 1'b1);
    check("R5 fe sticky", {15'd0, frameErr}, 16'd1);
    check("R5 later data", {8'd0, rxData}, 16'h22);
    pulseClrFe();
    check("R10 fe cleared", {15'd0, frameErr}, 16'd0);

    // R6 discard while pending
    sendFrame(8'h33, 1'b0, 1'b0, 1'b1);
    check("R6 data kept", {8'd0, rxData}, 16'h22);
    check("R6 ready kept", {15'd0, rxReady}, 16'd1);
    pulseClrReady();

    // R7 / R8 sweep, nine-bit filtered address frames
    addrFilterEn = 1'b1;
    frameNine = 1'b1;
    slaveAddr = 8'h5A;
    addrMask = 8'hF0;
    bc = slaveAddr | addrMask;
    for (int v = 0; v < 256; v++) begin
      expHit = (((8'(v) ^ slaveAddr) & addrMask) == 8'h00) || ((8'(v) & bc) == bc);
      sendFrame(8'(v), 1'b1, 1'b1, 1'b1);
      if (expHit && (((8'(v) ^ slaveAddr) & addrMask) != 8'h00))
        check("R8 broadcast", {15'd0, rxReady}, 16'd1);
      else
        check("R7 address filter", {15'd0, rxReady}, {15'd0, expHit});
      if (expHit) begin
        check("R7 address data", {8'd0, rxData}, 16'(v));
        pulseClrReady();
      end
    end
    sendFrame(8'h5A, 1'b1, 1'b0, 1'b1);
    check("R7 data frame ignored", {15'd0, rxReady}, 16'd0);

    // R9 eight-bit filtered frames
    frameNine = 1'b0;
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b1);
    check("R9 match good stop", {15'd0, rxReady}, 16'd1);
    pulseClrReady();
    sendFrame(8'h5A, 1'b0, 1'b0, 1'b0);
    check("R9 match bad stop ready", {15'd0, rxReady}, 16'd0);
    check("R9 match bad stop fe", {15'd0, frameErr}, 16'd1);
    pulseClrFe();
    sendFrame(8'h00, 1'b0, 1'b0, 1'b1);
    check("R9 no match", {15'd0, rxReady}, 16'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule